// File: doc/BRIEF.md
# Dual-Slot Transmit Packet Buffer

This block sits between a register bus and the byte-wide transmit input of a 10/100 Ethernet MAC. It holds two independent packet slots. Software picks a slot through a select register, streams the packet into it as 32-bit words through one shared data port, writes the packet length in bytes into that slot's length register, and sets the slot's start bit. The block then sends exactly the programmed number of bytes downstream under a valid/ready handshake. It flags the final byte with a last strobe.

When a slot has fully drained, its start bit clears and the slot's completion bit is latched in an interrupt status register. An enable mask gates the status bits onto one interrupt line. Because the slots are independent, software can fill one slot while the other drains. A slot started during another slot's drain follows it on the wire without an idle cycle. The register map uses word addresses 0 to 7: 0 slot select, 1 length of slot 0, 2 length of slot 1, 3 control of slot 0, 4 control of slot 1, 5 data port, 6 interrupt enable, 7 interrupt status.

Top module: `txslot_buffer`

## Requirements
- R1: After reset every register reads 0, `tx_valid` is 0 and `irq` is 0.
- R2: Bit 0 of the select register (address 0) steers data-port writes into slot 0 or slot 1. Writing the select register rewinds the chosen slot's word count to 0 unless that slot is busy. Reading the data port (address 5) returns the selected slot's stored word count.
- R3: Data-port writes are stored as consecutive words of the selected slot. A write is ignored when the slot already holds 1024 words (4096 bytes) or when the slot is busy.
- R4: Slot 0's length lives at address 1 and slot 1's at address 2, as a 13-bit byte count. A written value above 4096 is stored as 4096. A length write to a busy slot is ignored.
- R5: Writing 1 to bit 0 of a slot's control register (address 3 for slot 0, 4 for slot 1) makes the slot busy, and the bit reads back as 1. This only takes effect when the slot's length is nonzero. Writing 0 has no effect. The bit clears by itself in the cycle after the slot's last byte is accepted.
- R6: A slot sends exactly its length in bytes, least-significant byte of each word first. `tx_last` is high only with the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold.
- R7: If the other slot is busy when a slot's last byte is accepted, the other slot's first byte is valid in the next cycle, with no idle cycle in between.
- R8: A slot's completion sets interrupt status bit n (address 7, bit 0 for slot 0, bit 1 for slot 1). `irq` is high exactly when some status bit and the same bit of the enable register (address 6) are both set.
- R9: Writing ones to the status register clears those bits only. A completion in the same cycle wins over the clear.
- R10: `tx_valid` is high only while the slot being sent is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| tx_data | output | 8 | Byte to the MAC |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | MAC accepts the byte |
| irq | output | 1 | Slot-completion interrupt |

## Verification
The bench drives lengths of 1 to 5 bytes, which exercise a partly used final word. A lane-order or padding bug shows up there as swapped or extra bytes. It fills a slot past 4096 bytes, which would wrap the write pointer and overwrite word 0 if the guard were missing. It stalls `tx_ready` and writes into a busy slot, which would corrupt or shorten the packet being sent. It queues the second slot during a drain so that a sequencer that returns to idle first shows a one-cycle gap. Partial status clears and zero-length starts check that the wrong bit is not cleared and that an empty slot does not hang the transmit path.

// File: rtl/txb_pkg.sv
package txb_pkg;

  typedef enum logic [2:0] {
    A_SEL   = 3'd0,
    A_LEN0  = 3'd1,
    A_LEN1  = 3'd2,
    A_CTL0  = 3'd3,
    A_CTL1  = 3'd4,
    A_DATA  = 3'd5,
    A_IEN   = 3'd6,
    A_ISTAT = 3'd7
  } reg_addr_e;

  // Clamp a requested byte count to the slot capacity.
  function automatic logic [31:0] sat_len(input logic [31:0] req, input logic [31:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // Byte lane of a 32-bit word, lane 0 being the least significant byte.
  function automatic logic [7:0] lane_of(input logic [31:0] word, input logic [1:0] lane);
    return word[{lane, 3'b000} +: 8];
  endfunction

  // True when byte index idx is the final byte of a len-byte packet.
  function automatic logic last_byte(input logic [15:0] idx, input logic [15:0] len);
    return (idx + 16'd1) == len;
  endfunction

endpackage

// File: rtl/txb_slot_store.sv
module txb_slot_store #(
  parameter int SLOT_BYTES = 4096
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               data_we,
  input  logic [31:0]                        data_in,
  input  logic                               rewind,
  input  logic                               len_we,
  input  logic [31:0]                        len_in,
  input  logic                               start_we,
  input  logic                               done,
  input  logic [$clog2(SLOT_BYTES/4)-1:0]    rd_idx,
  output logic [31:0]                        rd_word,
  output logic [$clog2(SLOT_BYTES/4+1)-1:0]  wcount,
  output logic [$clog2(SLOT_BYTES+1)-1:0]    len,
  output logic                               busy
);
  import txb_pkg::*;

  localparam int WORDS = SLOT_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int WC_W  = $clog2(WORDS + 1);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);

  logic [31:0] mem [WORDS];

  // Named events for assertions.
  logic store_ok;
  logic start_ok;
  assign store_ok = data_we && !busy && (wcount < WC_W'(WORDS));
  assign start_ok = start_we && !busy && (len != '0);

  always_ff @(posedge clk) begin
    if (store_ok) mem[wcount[WA_W-1:0]] <= data_in;
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcount <= '0;
      len    <= '0;
      busy   <= 1'b0;
    end else begin
      if (rewind && !busy)  wcount <= '0;
      else if (store_ok)    wcount <= wcount + WC_W'(1);
      if (len_we && !busy)  len <= LEN_W'(sat_len(len_in, 32'(SLOT_BYTES)));
      if (done)             busy <= 1'b0;
      else if (start_ok)    busy <= 1'b1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= WC_W'(WORDS));
  a_r3_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(wcount) && $stable(len));
  a_r5_busy_has_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len != '0));
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/txb_drain_engine.sv
module txb_drain_engine #(
  parameter int SLOT_BYTES = 4096
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             busy,
  input  logic [1:0][$clog2(SLOT_BYTES+1)-1:0]   len,
  input  logic [1:0][31:0]                       word,
  output logic [$clog2(SLOT_BYTES/4)-1:0]        rd_idx,
  input  logic                                   tx_ready,
  output logic [7:0]                             tx_data,
  output logic                                   tx_valid,
  output logic                                   tx_last,
  output logic [1:0]                             done
);
  import txb_pkg::*;

  localparam int WA_W  = $clog2(SLOT_BYTES / 4);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);

  logic             active;
  logic             cur;
  logic [LEN_W-1:0] bidx;

  logic xfer;
  logic at_last;
  logic handoff;

  assign at_last  = last_byte(16'(bidx), 16'(len[cur]));
  assign xfer     = active && tx_ready;
  assign handoff  = xfer && at_last && busy[~cur];
  assign done[0]  = xfer && at_last && (cur == 1'b0);
  assign done[1]  = xfer && at_last && (cur == 1'b1);

  assign rd_idx   = bidx[WA_W+1:2];
  assign tx_valid = active;
  assign tx_data  = lane_of(word[cur], bidx[1:0]);
  assign tx_last  = active && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= 1'b0;
      bidx   <= '0;
    end else if (!active) begin
      bidx <= '0;
      if (busy[0]) begin
        active <= 1'b1;
        cur    <= 1'b0;
      end else if (busy[1]) begin
        active <= 1'b1;
        cur    <= 1'b1;
      end
    end else if (xfer) begin
      if (at_last) begin
        bidx <= '0;
        if (handoff) cur <= ~cur;
        else         active <= 1'b0;
      end else begin
        bidx <= bidx + LEN_W'(1);
      end
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> tx_valid);
  a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy[cur]);
  a_r6_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

endmodule

// File: rtl/txb_irq_block.sv
module txb_irq_block #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] done,
  input  logic             en_we,
  input  logic             clr_we,
  input  logic [31:0]      wdata,
  output logic [NSLOT-1:0] stat,
  output logic [NSLOT-1:0] en,
  output logic             irq
);
  logic [NSLOT-1:0] clr_mask;
  assign clr_mask = clr_we ? wdata[NSLOT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_mask) | done;
      if (en_we) en <= wdata[NSLOT-1:0];
    end
  end

  assign irq = |(stat & en);

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> stat[i]);
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !done[i]) |=> !stat[i]);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !clr_mask[i]) |=> stat[i]);
  end

endmodule

// File: rtl/txslot_buffer.sv
module txslot_buffer #(
  parameter int SLOT_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  import txb_pkg::*;

  localparam int WORDS = SLOT_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int WC_W  = $clog2(WORDS + 1);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);

  logic                       sel;
  logic [1:0]                 busy;
  logic [1:0]                 done;
  logic [1:0][LEN_W-1:0]      len;
  logic [1:0][WC_W-1:0]       wcount;
  logic [1:0][31:0]           word;
  logic [WA_W-1:0]            rd_idx;
  logic [1:0]                 stat;
  logic [1:0]                 en;

  always_ff @(posedge clk) begin
    if (!rst_n)                          sel <= 1'b0;
    else if (reg_we && reg_addr == A_SEL) sel <= reg_wdata[0];
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    txb_slot_store #(.SLOT_BYTES(SLOT_BYTES)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we  (reg_we && reg_addr == A_DATA && sel == 1'(s)),
      .data_in  (reg_wdata),
      .rewind   (reg_we && reg_addr == A_SEL && reg_wdata[0] == 1'(s)),
      .len_we   (reg_we && reg_addr == 3'(A_LEN0 + s)),
      .len_in   (reg_wdata),
      .start_we (reg_we && reg_addr == 3'(A_CTL0 + s) && reg_wdata[0]),
      .done     (done[s]),
      .rd_idx   (rd_idx),
      .rd_word  (word[s]),
      .wcount   (wcount[s]),
      .len      (len[s]),
      .busy     (busy[s])
    );
  end

  txb_drain_engine #(.SLOT_BYTES(SLOT_BYTES)) i_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .len      (len),
    .word     (word),
    .rd_idx   (rd_idx),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .done     (done)
  );

  txb_irq_block #(.NSLOT(2)) i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .en_we  (reg_we && reg_addr == A_IEN),
    .clr_we (reg_we && reg_addr == A_ISTAT),
    .wdata  (reg_wdata),
    .stat   (stat),
    .en     (en),
    .irq    (irq)
  );

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = {31'd0, sel};
      A_LEN0:  reg_rdata = 32'(len[0]);
      A_LEN1:  reg_rdata = 32'(len[1]);
      A_CTL0:  reg_rdata = {31'd0, busy[0]};
      A_CTL1:  reg_rdata = {31'd0, busy[1]};
      A_DATA:  reg_rdata = 32'(wcount[sel]);
      A_IEN:   reg_rdata = {30'd0, en};
      default: reg_rdata = {30'd0, stat};
    endcase
  end

  a_r8_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat & en));
  a_r5_start_needs_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> len[0] != '0);

endmodule

// File: tb/test_txslot_buffer.sv
module test_txslot_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_last;
  logic        tx_ready = 1'b0;
  logic        irq;

  txslot_buffer i_txslot_buffer (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, ready_mode = 1;
  bit ended = 0;
  logic [7:0] exp_a[$], exp_b[$], got_d[$];
  bit got_l[$];
  int got_c[$];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    tx_ready = (ready_mode == 0) ? 1'b0 : (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
    #1;
    if (tx_valid && tx_ready) begin
      got_d.push_back(tx_data); got_l.push_back(tx_last); got_c.push_back(cyc);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); reg_we = 1'b0; reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  function automatic int words_needed(int n); return (n + 3) / 4; endfunction

  // Fill slot with nwords random words; record the first len bytes, low lane first.
  task automatic fill(int slot, int len, int nwords);
    if (slot == 0) exp_a.delete(); else exp_b.delete();
    wr(3'd0, 32'(slot));
    for (int w = 0; w < nwords; w++) begin
      logic [31:0] d = $urandom;
      wr(3'd5, d);
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < len && w < 1024) begin
          if (slot == 0) exp_a.push_back(d[b*8 +: 8]); else exp_b.push_back(d[b*8 +: 8]);
        end
    end
    wr(3'(1 + slot), 32'(len));
  endtask

  task automatic wait_out(int n);
    for (int i = 0; i < 30000 && got_d.size() < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_out(logic [7:0] e[$], int first, string req);
    int ad = 0, ed = 0, nl = 0, li = -1;
    for (int i = 0; i < e.size(); i++) begin
      if (first + i >= got_d.size()) begin ad = -1; ed = int'(e[i]); break; end
      if (got_d[first + i] != e[i] && ad == ed) begin ad = int'(got_d[first+i]); ed = int'(e[i]); end
      if (got_l[first + i]) begin nl++; li = i; end
    end
    chk({req, " R6 byte data"}, ad, ed);
    chk({req, " R6 tx_last count"}, nl, 1);
    chk({req, " R6 tx_last position"}, li, e.size() - 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int v;
    int dir_len[6] = '{1, 2, 3, 4, 5, 61};
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reset register", v, 0); end
    chk("R1 reset tx_valid", int'(tx_valid), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2 select rewinds the word count
    wr(3'd0, 32'd1); wr(3'd5, 32'h11); wr(3'd5, 32'h22); wr(3'd5, 32'h33);
    rd(3'd5, v); chk("R2 word count slot1", v, 3);
    wr(3'd0, 32'd0); rd(3'd5, v); chk("R2 slot0 count independent", v, 0);
    wr(3'd0, 32'd1); rd(3'd5, v); chk("R2 rewind on select", v, 0);

    // R4 saturation, R5 zero length start ignored
    wr(3'd1, 32'd5000); rd(3'd1, v); chk("R4 length saturates", v, 4096);
    wr(3'd2, 32'd0); wr(3'd4, 32'd1); rd(3'd4, v); chk("R5 zero length start ignored", v, 0);
    chk("R5 no output for zero length", int'(tx_valid), 0);

    // Directed stall: busy slot ignores writes, data held
    ready_mode = 0;
    fill(0, 8, 2); wr(3'd6, 32'd3);
    wr(3'd3, 32'd1); rd(3'd3, v); chk("R5 start reads back", v, 1);
    wr(3'd3, 32'd0); rd(3'd3, v); chk("R5 writing 0 no effect", v, 1);
    wr(3'd5, 32'hdead); rd(3'd5, v); chk("R3 busy slot ignores data", v, 2);
    wr(3'd1, 32'd20); rd(3'd1, v); chk("R4 busy slot ignores length", v, 8);
    wr(3'd0, 32'd0); wr(3'd0, 32'd0); rd(3'd5, v); chk("R2 busy slot not rewound", v, 2);
    chk("R6 held valid under stall", int'(tx_valid), 1);
    chk("R6 held first byte", int'(tx_data), int'(exp_a[0]));

    // R7 queue slot1 behind slot0, release
    fill(1, 6, 2); wr(3'd4, 32'd1);
    got_d.delete(); got_l.delete(); got_c.delete();
    ready_mode = 1;
    wait_out(14);
    cmp_out(exp_a, 0, "R7 first slot0");
    cmp_out(exp_b, 8, "R7 then slot1");
    if (got_c.size() >= 9) chk("R7 no idle cycle between slots", got_c[8] - got_c[7], 1);
    else chk("R7 second slot output", got_c.size(), 14);
    rd(3'd7, v); chk("R8 both status bits", v, 3);
    chk("R8 irq with enable", int'(irq), 1);
    wr(3'd7, 32'd1); rd(3'd7, v); chk("R9 clear only bit0", v, 2);
    wr(3'd6, 32'd1); chk("R8 irq masked", int'(irq), 0);
    wr(3'd7, 32'd2); rd(3'd7, v); chk("R9 clear bit1", v, 0);

    // Random packets
    for (int it = 0; it < 14; it++) begin
      int s = $urandom % 2;
      int len = (it < 6) ? dir_len[it] : 1 + ($urandom % 300);
      int en = $urandom % 4;
      ready_mode = (it % 3 == 0) ? 1 : 2;
      wr(3'd6, 32'(en));
      fill(s, len, words_needed(len));
      got_d.delete(); got_l.delete(); got_c.delete();
      wr(3'(3 + s), 32'd1);
      wait_out(len);
      chk("R6 byte count", got_d.size(), len);
      cmp_out((s == 0) ? exp_a : exp_b, 0, "random");
      rd(3'(3 + s), v); chk("R5 start self-clears", v, 0);
      rd(3'd7, v); chk("R8 status bit of slot", v, 1 << s);
      chk("R8 irq follows enable", int'(irq), ((en >> s) & 1));
      wr(3'd7, 32'(v)); rd(3'd7, v); chk("R9 write back clears", v, 0);
    end

    // R3 capacity: 1025 words, last ignored; drain full 4096 bytes
    ready_mode = 1;
    fill(0, 4096, 1025);
    rd(3'd5, v); chk("R3 capacity limit", v, 1024);
    got_d.delete(); got_l.delete(); got_c.delete();
    wr(3'd3, 32'd1);
    wait_out(4096);
    chk("R6 full slot byte count", got_d.size(), 4096);
    cmp_out(exp_a, 0, "R3 full slot");
    chk("R10 idle after drain", int'(tx_valid), 0);

    finish_run();
  end
endmodule